// File: doc/BRIEF.md
# Lamp Persistence Level Integrator

This block gives a bank of logic inputs the sluggish look of incandescent indicator lamps. Every input owns a 5-bit brightness level, where 0 means dark and 31 means fully lit. A divider built from the system clock produces a slow sample pulse, nominally 60 per second. On each pulse every level takes one step toward its input: up while the input is high, down while it is low. Each level stops at both ends of its range. An input that switches therefore fades in or out over about half a second instead of snapping, which mimics the thermal lag of a filament.

Inputs arrive asynchronously and pass through a two-flop synchroniser before the integrators use them. A downstream lamp driver reads levels one at a time. It puts an input number on the index port, and the matching level appears combinationally in the same cycle. The sample pulse is also brought out so that a driver can align with level updates.

Top module: `lamp_level_bank`

## Requirements
- R1: While the synchronous active-high reset is asserted, the sample pulse is low. From the first edge onward every level reads 0.
- R2: The sample pulse is high for exactly one clock cycle. Successive pulses are CLK_HZ/SAMPLE_HZ cycles apart, which is 10 cycles with the bench parameters.
- R3: On the clock edge that ends a pulse-high cycle, a level below 31 whose synchronised input is high goes up by exactly one.
- R4: On that same edge, a level above 0 whose synchronised input is low goes down by exactly one.
- R5: A level at 31 with its synchronised input high stays at 31.
- R6: A level at 0 with its synchronised input low stays at 0.
- R7: On clock edges that do not end a pulse-high cycle, no level changes.
- R8: The integrators see each input through two register stages. An update edge uses the value the input had two edges earlier, so a change applied after the edge just before the update edge has no effect on that update.
- R9: The level output shows the level of the input named by the index port, combinationally. An index of N_LAMPS or higher reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lamp_in | input | N_LAMPS | Asynchronous logic inputs, one per lamp |
| rd_idx | input | IDX_W | Input number to read |
| rd_level | output | 5 | Level of the selected input, 0..31 |
| tick_o | output | 1 | One-cycle sample pulse |

## Verification
A level update is due on the clock edge that follows the cycle in which the sample pulse is high. The bench therefore samples every negative edge and compares all indices against the expected level set. When it sees the pulse high, it queues the next expected set, computed from a two-stage copy of the inputs, and checks that set at the following negative edge. On every other negative edge it expects the levels unchanged. Inputs are changed 2 ns after a rising edge, and the pulse spacing is counted in negative edges. One directed case flips the inputs just after the pulse rises, so that the change must not appear until one pulse later.

// File: rtl/lamp_pkg.sv
package lamp_pkg;
   localparam int unsigned LEVEL_BITS = 5;

   function automatic int unsigned index_bits(input int unsigned count);
      return (count <= 1) ? 1 : $clog2(count);
   endfunction
endpackage

// File: rtl/lamp_tick_gen.sv
module lamp_tick_gen #(
   parameter int unsigned PERIOD = 4
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   localparam int unsigned CW = $clog2(PERIOD);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= (cnt_q == LAST);
         cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lamp_in_sync.sv
module lamp_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst)
            stg_q[s] <= '0;
         else if (s == 0)
            stg_q[s] <= d_i;
         else
            stg_q[s] <= stg_q[(s == 0) ? 0 : s - 1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lamp_level_cell.sv
module lamp_level_cell #(
   parameter int unsigned LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_i,
   input  logic             up_i,
   output logic [LVL_W-1:0] level_o
);
   localparam logic [LVL_W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (rst)
         level_o <= '0;
      else if (step_i) begin
         if (up_i && level_o != TOP)
            level_o <= level_o + 1'b1;
         else if (!up_i && level_o != '0)
            level_o <= level_o - 1'b1;
      end
   end
endmodule

// File: rtl/lamp_level_bank.sv
module lamp_level_bank #(
   parameter int unsigned N_LAMPS     = 8,
   parameter int unsigned LVL_W       = lamp_pkg::LEVEL_BITS,
   parameter int unsigned CLK_HZ      = 125_000_000,
   parameter int unsigned SAMPLE_HZ   = 60,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W      = lamp_pkg::index_bits(N_LAMPS)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_LAMPS-1:0] lamp_in,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [LVL_W-1:0]   rd_level,
   output logic               tick_o
);
   localparam int unsigned SAMPLE_DIV = CLK_HZ / SAMPLE_HZ;

   if (SAMPLE_DIV < 4) begin : g_bad_div
      $error("lamp_level_bank: CLK_HZ/SAMPLE_HZ must be at least 4");
   end
   if (N_LAMPS < 1) begin : g_bad_count
      $error("lamp_level_bank: N_LAMPS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lamp_level_bank: SYNC_STAGES must be at least 2");
   end
   if (LVL_W < 2) begin : g_bad_width
      $error("lamp_level_bank: LVL_W must be at least 2");
   end

   logic [N_LAMPS-1:0]            sync_q;
   logic [N_LAMPS-1:0][LVL_W-1:0] lvl_q;

   lamp_tick_gen #(.PERIOD(SAMPLE_DIV)) tick_i (
      .clk    (clk),
      .rst    (rst),
      .tick_o (tick_o)
   );

   lamp_in_sync #(.WIDTH(N_LAMPS), .STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rst (rst),
      .d_i (lamp_in),
      .q_o (sync_q)
   );

   for (genvar i = 0; i < N_LAMPS; i++) begin : g_cell
      lamp_level_cell #(.LVL_W(LVL_W)) cell_i (
         .clk     (clk),
         .rst     (rst),
         .step_i  (tick_o),
         .up_i    (sync_q[i]),
         .level_o (lvl_q[i])
      );
   end

   always_comb begin
      rd_level = '0;
      for (int i = 0; i < N_LAMPS; i++) begin
         if (rd_idx == IDX_W'(i))
            rd_level = lvl_q[i];
      end
   end
endmodule

// File: rtl/lamp_level_bank_chk.sv
module lamp_level_bank_chk #(
   parameter int unsigned N_LAMPS = 8,
   parameter int unsigned LVL_W   = 5,
   parameter int unsigned DIV     = 4,
   parameter int unsigned IDX_W   = 3
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          tick,
   input logic [N_LAMPS-1:0]            sync_q,
   input logic [N_LAMPS-1:0][LVL_W-1:0] lvl_q,
   input logic [IDX_W-1:0]              rd_idx,
   input logic [LVL_W-1:0]              rd_level
);
   localparam int unsigned GW = $clog2(DIV + 1) + 1;
   localparam logic [LVL_W-1:0] TOP = '1;

   logic [GW-1:0] gap_q;
   always_ff @(posedge clk) begin
      if (rst)
         gap_q <= '0;
      else if (tick)
         gap_q <= GW'(1);
      else
         gap_q <= gap_q + 1'b1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> (rd_level == '0 && !tick));

   // R2
   tick_spacing_chk: assert property (@(posedge clk) disable iff (rst) tick |-> gap_q == GW'(DIV));

   // R2
   tick_width_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);

   // R7
   hold_read_chk: assert property (@(posedge clk) disable iff (rst)
      (!tick && !$past(rst)) |=> ($stable(rd_idx) |-> $stable(rd_level)));

   for (genvar i = 0; i < N_LAMPS; i++) begin : g_lamp
      // R3
      step_up_chk: assert property (@(posedge clk) disable iff (rst)
         (tick && sync_q[i] && lvl_q[i] != TOP) |=> lvl_q[i] == $past(lvl_q[i]) + 1'b1);
      // R4
      step_down_chk: assert property (@(posedge clk) disable iff (rst)
         (tick && !sync_q[i] && lvl_q[i] != '0) |=> lvl_q[i] == $past(lvl_q[i]) - 1'b1);
      // R5
      top_sat_chk: assert property (@(posedge clk) disable iff (rst)
         (tick && sync_q[i] && lvl_q[i] == TOP) |=> lvl_q[i] == TOP);
      // R6
      floor_sat_chk: assert property (@(posedge clk) disable iff (rst)
         (tick && !sync_q[i] && lvl_q[i] == '0) |=> lvl_q[i] == '0);
   end
endmodule

bind lamp_level_bank lamp_level_bank_chk #(
   .N_LAMPS (N_LAMPS),
   .LVL_W   (LVL_W),
   .DIV     (SAMPLE_DIV),
   .IDX_W   (IDX_W)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .tick     (tick_o),
   .sync_q   (sync_q),
   .lvl_q    (lvl_q),
   .rd_idx   (rd_idx),
   .rd_level (rd_level)
);

// File: tb/lamp_level_bank_tb_top.sv
`timescale 1ns/1ps
module lamp_level_bank_tb_top;
   localparam int N   = 6;
   localparam int DIV = 10;
   localparam int IW  = 3;

   typedef struct packed {
      logic [N*5-1:0] lv;
      logic [N*5-1:0] prev;
      logic [N-1:0]   up;
      logic           late;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  lamp_in = '0;
   logic [IW-1:0] rd_idx = '0;
   logic [4:0]    rd_level;
   logic          tick_o;

   int checks = 0;
   int errors = 0;
   bit mon_en = 0;
   bit late_req = 0;

   logic [N-1:0]   s1m = '0, s2m = '0;
   logic [N*5-1:0] cur_lv = '0;
   exp_t           sb_q[$];
   int             gap = 0;
   bit             seen = 0;

   lamp_level_bank #(.N_LAMPS(N), .CLK_HZ(600), .SAMPLE_HZ(60)) dut_i (
      .clk      (clk),
      .rst      (rst),
      .lamp_in  (lamp_in),
      .rd_idx   (rd_idx),
      .rd_level (rd_level),
      .tick_o   (tick_o)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // input model: two register stages, as R8 states
   always @(posedge clk) begin
      if (rst) begin
         s1m = '0;
         s2m = '0;
      end else begin
         s2m = s1m;
         s1m = lamp_in;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst || !mon_en) begin
         sb_q.delete();
         cur_lv = '0;
         gap = 0;
         seen = 0;
      end else begin
         logic tk;
         logic [N-1:0] s2;
         exp_t ent;
         bit upd;
         tk = tick_o;
         s2 = s2m;
         upd = (sb_q.size() != 0);
         if (upd) ent = sb_q.pop_front();
         else ent = '{lv: cur_lv, prev: cur_lv, up: '0, late: 1'b0};
         for (int k = 0; k < 8; k++) begin
            int ev;
            string tag;
            rd_idx = IW'(k);
            #0.2;
            if (k >= N) begin
               ev = 0;
               tag = "R9";
            end else begin
               ev = int'(ent.lv[k*5 +: 5]);
               if (!upd) tag = "R7";
               else if (ent.late) tag = "R8";
               else if (ent.up[k]) tag = (ent.prev[k*5 +: 5] == 5'd31) ? "R5" : "R3";
               else tag = (ent.prev[k*5 +: 5] == 5'd0) ? "R6" : "R4";
            end
            check(rd_level == 5'(ev), tag, int'(rd_level), ev);
         end
         cur_lv = ent.lv;
         gap++;
         if (tk) begin
            exp_t nx;
            if (seen) check(gap == DIV, "R2", gap, DIV);
            gap = 0;
            seen = 1;
            nx.prev = cur_lv;
            nx.up = s2;
            nx.late = late_req;
            late_req = 0;
            for (int k = 0; k < N; k++) begin
               int v;
               v = int'(cur_lv[k*5 +: 5]);
               if (s2[k]) v = (v == 31) ? 31 : v + 1;
               else v = (v == 0) ? 0 : v - 1;
               nx.lv[k*5 +: 5] = 5'(v);
            end
            sb_q.push_back(nx);
         end
      end
   end

   task automatic drive(input logic [N-1:0] v, input int n_ticks);
      @(posedge clk);
      #2 lamp_in = v;
      repeat (n_ticks * DIV) @(posedge clk);
   endtask

   task automatic reset_check();
      for (int k = 0; k < 8; k++) begin
         rd_idx = IW'(k);
         #0.2;
         check(rd_level == 5'd0, "R1", int'(rd_level), 0);
      end
      check(tick_o == 1'b0, "R1", int'(tick_o), 0);
   endtask

   task automatic late_flip();
      do begin
         @(posedge clk);
         #1;
      end while (!tick_o);
      #1 lamp_in = ~lamp_in;
      late_req = 1;
      repeat (2 * DIV) @(posedge clk);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      reset_check();
      @(negedge clk);
      rst = 1'b0;
      mon_en = 1;

      drive('1, 40);
      drive('0, 40);
      drive(6'b101100, 12);
      drive(6'b010011, 6);
      for (int t = 0; t < 8; t++) drive(lamp_in ^ 6'b000001, 1);
      drive(6'b110101, 8);
      late_flip();
      late_flip();
      late_flip();

      @(negedge clk);
      mon_en = 0;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      reset_check();
      @(negedge clk);
      rst = 1'b0;
      mon_en = 1;
      drive(6'b111111, 5);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule